// File: doc/BRIEF.md
# Extended-Escape Prefix Classifier

This block looks at the first bytes of an x86-style instruction stream and decides whether the leading byte opens a vector-extension escape prefix or is an ordinary one-byte legacy opcode. Five lead bytes are candidates. C5 opens a two-byte prefix and C4 a three-byte prefix. 62 opens a four-byte vendor form whose second and third bytes carry the same fields as the three-byte form. D4 and D5 reuse the two obsolete BCD-adjust opcodes as a three-byte and a two-byte prefix.

In 64-bit mode the legacy meanings of all five bytes are invalid, so each of them is always a prefix. In legacy mode a candidate counts as a prefix only when the top two bits of the following byte are both 1, because those bits would name a register operand that the legacy instruction cannot take. In legacy mode the BCD reuse is also gated by a software enable. For each valid window the block reports the prefix kind, its length, the map-select field, a vendor-territory flag, a reserved-bits flag, a flag for reclaimed vendor opcodes, and a flag that says the window is too short to finish the decision.

The block is controlled by a two-state machine. ST_IDLE holds the outputs at zero. The IDLE-to-REPORT transition happens on a clock edge where a window is presented. REPORT-to-REPORT covers back-to-back windows. REPORT-to-IDLE happens on an edge with no window. While in ST_REPORT the registered result of the last window is shown.

Top module: `esc_prefix_classifier`

## Requirements
- R1: A window sampled with `win_valid` high on a rising edge produces `res_valid` = 1 and its result after that edge. An edge with `win_valid` low clears `res_valid` and drives every result field to zero. During reset and after it, all outputs are zero.
- R2: Lead byte C5 gives kind 1 with length 2, and C4 gives kind 2 with length 3. This holds for any next byte when `mode_64` = 1. When `mode_64` = 0 it holds only if bits [7:6] of byte 1 are 11; otherwise the result is kind 0 with length 0.
- R3: Lead byte 62 gives kind 3 with length 4, under the same mode and top-two-bits rule as R2.
- R4: Lead byte D4 gives kind 4 with length 3, and D5 gives kind 5 with length 2. This holds whenever `mode_64` = 1. When `mode_64` = 0 it holds only if `bcd_esc_en` = 1 and bits [7:6] of byte 1 are 11. When `mode_64` = 0 and `bcd_esc_en` = 0, both bytes are always kind 0.
- R5: Every other lead byte gives kind 0 (legacy) with length 0, and all flags and fields are zero except `res_need_more` as set by R10.
- R6: For kinds 2, 3 and 4, `res_map` equals bits [4:0] of byte 1. For kinds 1 and 5, `res_map` is 1.
- R7: For kind 3, `res_vendor` equals bit 7 of byte 3, provided bits [6:0] of byte 3 are zero. For all other kinds, `res_vendor` is 0.
- R8: For kind 3, any nonzero bit in bits [6:0] of byte 3 sets `res_invalid` and forces `res_vendor` and `res_reclaim` to 0.
- R9: `res_reclaim` is 1 only when all of these hold: the kind is a prefix kind, the encoding is not invalid, `res_map` = 1, the window holds a byte at index `res_len`, and that byte is one of 0E, 0F, 24, 25, 7A or 7B.
- R10: `res_need_more` is 1 in three cases: when `win_count` is 0; when a candidate lead byte is seen in legacy mode with `win_count` < 2 (the result is then kind 0); and when a prefix is detected with `win_count` below its length. Whenever `res_need_more` is 1, `res_map`, `res_vendor`, `res_invalid` and `res_reclaim` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | A byte window is presented this cycle |
| win_bytes | input | 8*WIN_BYTES | Byte window; byte i sits at bits [8i+7:8i], byte 0 is the lead byte |
| win_count | input | clog2(WIN_BYTES+1) | Number of valid bytes in the window |
| mode_64 | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| bcd_esc_en | input | 1 | Software enable for D4/D5 prefixes in legacy mode |
| res_valid | output | 1 | Result registers hold a classified window |
| res_kind | output | 3 | 0 legacy, 1 C5, 2 C4, 3 62, 4 D4, 5 D5 |
| res_len | output | 3 | Prefix length in bytes (0 for legacy) |
| res_need_more | output | 1 | Window too short to decide or to hold the prefix |
| res_map | output | 5 | Map-select field |
| res_vendor | output | 1 | Vendor-territory bit of the four-byte form |
| res_invalid | output | 1 | Reserved bits set in the four-byte form |
| res_reclaim | output | 1 | Opcode after the prefix is a reclaimed vendor opcode |

## Verification
Every result passes through exactly one register. A window driven before a rising edge therefore appears on the outputs just after that edge, and the clear caused by a gap appears one edge after the gap. The bench changes inputs on the falling edge and compares all result fields at the next falling edge, which is half a cycle after the result register has loaded. It sweeps all 256 lead bytes across both modes, both enable values and a set of next-byte patterns whose top bits and map fields vary. A second sweep runs the candidate bytes across every window count, so that the short-window, length and reclaim-boundary cases all occur.

// File: rtl/esc_pkg.sv
package esc_pkg;

    localparam int BYTE_W    = 8;
    localparam int LEN_W     = 3;
    localparam int MAP_W     = 5;
    localparam int RECLAIM_N = 6;

    // Opcodes reclaimed for the vendor when the map field is 1
    localparam logic [RECLAIM_N*BYTE_W-1:0] RECLAIM_OPS =
        {8'h7B, 8'h7A, 8'h25, 8'h24, 8'h0F, 8'h0E};

    localparam logic [BYTE_W-1:0] LEAD_ESC2 = 8'hC5;
    localparam logic [BYTE_W-1:0] LEAD_ESC3 = 8'hC4;
    localparam logic [BYTE_W-1:0] LEAD_ESC4 = 8'h62;
    localparam logic [BYTE_W-1:0] LEAD_BCD3 = 8'hD4;
    localparam logic [BYTE_W-1:0] LEAD_BCD2 = 8'hD5;

    typedef enum logic [2:0] {
        PK_LEGACY = 3'd0,
        PK_ESC2   = 3'd1,
        PK_ESC3   = 3'd2,
        PK_ESC4   = 3'd3,
        PK_BCD3   = 3'd4,
        PK_BCD2   = 3'd5
    } pfx_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } cls_state_e;

    typedef struct packed {
        pfx_kind_e          kind;
        logic [LEN_W-1:0]   len;
        logic               need_more;
        logic [MAP_W-1:0]   map;
        logic               vendor;
        logic               invalid;
        logic               reclaim;
    } cls_result_t;

endpackage

// File: rtl/esc_lead_decode.sv
module esc_lead_decode
    import esc_pkg::*;
(
    input  logic [BYTE_W-1:0] lead,
    input  logic [1:0]        next_top,
    input  logic              have_lead,
    input  logic              have_next,
    input  logic              mode_64,
    input  logic              bcd_en,
    output pfx_kind_e         kind,
    output logic [LEN_W-1:0]  len,
    output logic              pending
);

    logic             cand;
    logic             decided;
    pfx_kind_e        form;
    logic [LEN_W-1:0] form_len;

    always_comb begin
        cand     = 1'b1;
        form     = PK_LEGACY;
        form_len = '0;
        unique case (lead)
            LEAD_ESC2: begin form = PK_ESC2; form_len = LEN_W'(2); end
            LEAD_ESC3: begin form = PK_ESC3; form_len = LEN_W'(3); end
            LEAD_ESC4: begin form = PK_ESC4; form_len = LEN_W'(4); end
            LEAD_BCD3: begin
                cand     = mode_64 | bcd_en;
                form     = PK_BCD3;
                form_len = LEN_W'(3);
            end
            LEAD_BCD2: begin
                cand     = mode_64 | bcd_en;
                form     = PK_BCD2;
                form_len = LEN_W'(2);
            end
            default:   cand = 1'b0;
        endcase
        cand = cand & have_lead;

        // legacy opcodes cannot take a register operand here, so 11 marks a prefix
        decided = mode_64 | (have_next & (next_top == 2'b11));
        pending = cand & ~mode_64 & ~have_next;

        if (cand & decided) begin
            kind = form;
            len  = form_len;
        end else begin
            kind = PK_LEGACY;
            len  = '0;
        end
    end

endmodule

// File: rtl/esc_field_extract.sv
module esc_field_extract
    import esc_pkg::*;
#(
    parameter int WIN_BYTES = 5,
    parameter int CNT_W     = 3
) (
    input  logic [WIN_BYTES*BYTE_W-1:0] window,
    input  logic [CNT_W-1:0]            count,
    input  pfx_kind_e                   kind,
    input  logic [LEN_W-1:0]            len,
    input  logic                        pending,
    output cls_result_t                 res
);

    logic [BYTE_W-1:0]    op;
    logic [RECLAIM_N-1:0] op_hit;

    // opcode byte that follows the prefix
    always_comb begin
        op = '0;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (i == int'(len)) op = window[BYTE_W*i +: BYTE_W];
        end
    end

    genvar g;
    generate
        for (g = 0; g < RECLAIM_N; g++) begin : g_reclaim_cmp
            assign op_hit[g] = (op == RECLAIM_OPS[BYTE_W*g +: BYTE_W]);
        end
    endgenerate

    always_comb begin
        int               cnt_i;
        int               len_i;
        logic             prefix;
        logic             short_win;
        logic [MAP_W-1:0] map_raw;
        logic [BYTE_W-1:0] ext_b;
        logic             inv_raw;

        cnt_i     = int'(count);
        len_i     = int'(len);
        prefix    = (kind != PK_LEGACY);
        short_win = (cnt_i == 0) | pending | (prefix & (cnt_i < len_i));
        map_raw   = ((kind == PK_ESC2) || (kind == PK_BCD2))
                    ? MAP_W'(1) : window[BYTE_W +: MAP_W];
        ext_b     = window[3*BYTE_W +: BYTE_W];
        inv_raw   = (kind == PK_ESC4) & (|ext_b[BYTE_W-2:0]);

        res           = '0;
        res.kind      = kind;
        res.len       = len;
        res.need_more = short_win;
        if (prefix & ~short_win) begin
            res.map     = map_raw;
            res.invalid = inv_raw;
            res.vendor  = (kind == PK_ESC4) & ext_b[BYTE_W-1] & ~inv_raw;
            res.reclaim = ~inv_raw & (map_raw == MAP_W'(1))
                          & (cnt_i > len_i) & (|op_hit);
        end
    end

endmodule

// File: rtl/esc_prefix_classifier.sv
module esc_prefix_classifier
    import esc_pkg::*;
#(
    parameter  int WIN_BYTES = 5,
    localparam int CNT_W     = $clog2(WIN_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_valid,
    input  logic [WIN_BYTES*BYTE_W-1:0] win_bytes,
    input  logic [CNT_W-1:0]            win_count,
    input  logic                        mode_64,
    input  logic                        bcd_esc_en,
    output logic                        res_valid,
    output logic [2:0]                  res_kind,
    output logic [LEN_W-1:0]            res_len,
    output logic                        res_need_more,
    output logic [MAP_W-1:0]            res_map,
    output logic                        res_vendor,
    output logic                        res_invalid,
    output logic                        res_reclaim
);

    cls_state_e       state_q, state_d;
    cls_result_t      comb_res, res_q;
    pfx_kind_e        lead_kind;
    logic [LEN_W-1:0] lead_len;
    logic             lead_pending;
    logic             have_lead, have_next;

    assign have_lead = (int'(win_count) >= 1);
    assign have_next = (int'(win_count) >= 2);

    esc_lead_decode u_lead (
        .lead      (win_bytes[BYTE_W-1:0]),
        .next_top  (win_bytes[2*BYTE_W-1 -: 2]),
        .have_lead (have_lead),
        .have_next (have_next),
        .mode_64   (mode_64),
        .bcd_en    (bcd_esc_en),
        .kind      (lead_kind),
        .len       (lead_len),
        .pending   (lead_pending)
    );

    esc_field_extract #(
        .WIN_BYTES (WIN_BYTES),
        .CNT_W     (CNT_W)
    ) u_fields (
        .window  (win_bytes),
        .count   (win_count),
        .kind    (lead_kind),
        .len     (lead_len),
        .pending (lead_pending),
        .res     (comb_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: IDLE->REPORT on window, REPORT->REPORT back-to-back, REPORT->IDLE on gap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = win_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = win_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         res_q <= '0;
        else if (win_valid) res_q <= comb_res;
        else                res_q <= '0;
    end

    // output process
    always_comb begin
        res_valid     = (state_q == ST_REPORT);
        res_kind      = res_q.kind;
        res_len       = res_q.len;
        res_need_more = res_q.need_more;
        res_map       = res_q.map;
        res_vendor    = res_q.vendor;
        res_invalid   = res_q.invalid;
        res_reclaim   = res_q.reclaim;
    end

    AST_REPORT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> res_valid); // R1
    AST_IDLE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> (!res_valid && res_kind == 3'd0 && res_len == '0)); // R1
    AST_LEGACY_NO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 3'd0) |-> (res_len == '0 && !res_vendor && !res_reclaim)); // R5
    AST_BCD_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_kind == 3'd4 || res_kind == 3'd5)) |-> $past(mode_64 || bcd_esc_en)); // R4
    AST_INVALID_NO_VENDOR: assert property (@(posedge clk) disable iff (!rst_n)
        res_invalid |-> (!res_vendor && !res_reclaim && res_kind == 3'd3)); // R8
    AST_RECLAIM_MAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_reclaim |-> (res_map == MAP_W'(1) && res_kind != 3'd0)); // R9
    AST_SHORT_NO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        res_need_more |-> (res_map == '0 && !res_vendor && !res_invalid && !res_reclaim)); // R10

endmodule

// File: tb/sim_esc_prefix_classifier.sv
module sim_esc_prefix_classifier;

    typedef struct packed {
        logic [2:0] kind;
        logic [2:0] len;
        logic       need;
        logic [4:0] map;
        logic       vendor;
        logic       invalid;
        logic       reclaim;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        win_valid;
    logic [39:0] win_bytes;
    logic [2:0]  win_count;
    logic        mode_64;
    logic        bcd_esc_en;
    logic        res_valid;
    logic [2:0]  res_kind;
    logic [2:0]  res_len;
    logic        res_need_more;
    logic [4:0]  res_map;
    logic        res_vendor;
    logic        res_invalid;
    logic        res_reclaim;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    esc_prefix_classifier u0 (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_bytes(win_bytes),
        .win_count(win_count), .mode_64(mode_64), .bcd_esc_en(bcd_esc_en),
        .res_valid(res_valid), .res_kind(res_kind), .res_len(res_len),
        .res_need_more(res_need_more), .res_map(res_map), .res_vendor(res_vendor),
        .res_invalid(res_invalid), .res_reclaim(res_reclaim)
    );

    function automatic exp_t model(logic [39:0] w, int cnt, bit m64, bit en);
        exp_t       e;
        logic [7:0] b [5];
        bit         cand;
        int         fk, fl;
        logic [7:0] op;
        e = '0;
        for (int i = 0; i < 5; i++) b[i] = w[8*i +: 8];
        cand = 1'b1; fk = 0; fl = 0;
        case (b[0])
            8'hC5: begin fk = 1; fl = 2; end
            8'hC4: begin fk = 2; fl = 3; end
            8'h62: begin fk = 3; fl = 4; end
            8'hD4: begin fk = 4; fl = 3; cand = m64 || en; end
            8'hD5: begin fk = 5; fl = 2; cand = m64 || en; end
            default: cand = 1'b0;
        endcase
        if (cnt == 0) begin e.need = 1'b1; return e; end
        if (!cand) return e;
        if (!m64 && cnt < 2) begin e.need = 1'b1; return e; end
        if (!m64 && b[1][7:6] != 2'b11) return e;
        e.kind = 3'(fk);
        e.len  = 3'(fl);
        if (cnt < fl) begin e.need = 1'b1; return e; end
        e.map     = (fl == 2) ? 5'd1 : b[1][4:0];
        e.invalid = (fk == 3) && (b[3][6:0] != 7'd0);
        e.vendor  = (fk == 3) && b[3][7] && !e.invalid;
        op        = b[fl];
        e.reclaim = !e.invalid && (e.map == 5'd1) && (cnt > fl) &&
                    (op inside {8'h0E, 8'h0F, 8'h24, 8'h25, 8'h7A, 8'h7B});
        return e;
    endfunction

    task automatic chk(string req, string name, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h (lead %02h cnt %0d m64 %0b en %0b)",
                     req, name, act, exp, win_bytes[7:0], win_count, mode_64, bcd_esc_en);
        end
    endtask

    task automatic compare(exp_t e, bit vld);
        string kreq;
        case (win_bytes[7:0])
            8'hC4, 8'hC5: kreq = "R2";
            8'h62:        kreq = "R3";
            8'hD4, 8'hD5: kreq = "R4";
            default:      kreq = "R5";
        endcase
        chk("R1",  "valid",   int'(res_valid),     int'(vld));
        chk(kreq,  "kind",    int'(res_kind),      int'(e.kind));
        chk(kreq,  "len",     int'(res_len),       int'(e.len));
        chk("R10", "need",    int'(res_need_more), int'(e.need));
        chk("R6",  "map",     int'(res_map),       int'(e.map));
        chk("R7",  "vendor",  int'(res_vendor),    int'(e.vendor));
        chk("R8",  "invalid", int'(res_invalid),   int'(e.invalid));
        chk("R9",  "reclaim", int'(res_reclaim),   int'(e.reclaim));
    endtask

    // drive at falling edge, result registered at next rising edge, compare at following falling edge
    task automatic run(logic [39:0] w, int cnt, bit m64, bit en);
        win_bytes  = w;
        win_count  = 3'(cnt);
        mode_64    = m64;
        bcd_esc_en = en;
        win_valid  = 1'b1;
        @(negedge clk);
        compare(model(w, cnt, m64, en), 1'b1);
    endtask

    initial begin
        logic [7:0] nxt_list [9] = '{8'h00, 8'h3F, 8'h40, 8'h80, 8'hBF, 8'hC0, 8'hC1, 8'hE3, 8'hFF};
        logic [7:0] b3_list  [6] = '{8'h00, 8'h80, 8'h01, 8'h81, 8'h0E, 8'h7B};
        logic [7:0] op_list  [9] = '{8'h0E, 8'h0F, 8'h24, 8'h25, 8'h7A, 8'h7B, 8'h0D, 8'h7C, 8'h26};
        logic [7:0] lead_set [6] = '{8'hC4, 8'hC5, 8'h62, 8'hD4, 8'hD5, 8'h90};
        logic [7:0] nx3      [3] = '{8'h00, 8'hC1, 8'hE0};
        logic [7:0] b3s      [2] = '{8'h00, 8'h80};
        logic [7:0] ops      [2] = '{8'h0E, 8'h24};

        rst_n = 1'b0; win_valid = 1'b0; win_bytes = '0; win_count = '0;
        mode_64 = 1'b0; bcd_esc_en = 1'b0;
        repeat (3) @(negedge clk);
        compare('0, 1'b0);                       // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);
        compare('0, 1'b0);                       // R1 idle after reset

        // full sweep of lead bytes, modes, enable and next-byte patterns: R2..R9
        for (int l = 0; l < 256; l++)
            for (int m = 0; m < 2; m++)
                for (int en = 0; en < 2; en++)
                    for (int ni = 0; ni < 9; ni++)
                        run({op_list[(l + 2*ni) % 9], b3_list[(l + ni) % 6],
                             op_list[(3*l + ni) % 9], nxt_list[ni], 8'(l)},
                            5, m[0], en[0]);

        // window-count sweep on candidates: R10 and reclaim boundary R9
        for (int li = 0; li < 6; li++)
            for (int c = 0; c <= 5; c++)
                for (int m = 0; m < 2; m++)
                    for (int en = 0; en < 2; en++)
                        for (int ni = 0; ni < 3; ni++)
                            for (int bi = 0; bi < 2; bi++)
                                for (int oi = 0; oi < 2; oi++)
                                    run({ops[oi], b3s[bi], ops[oi], nx3[ni], lead_set[li]},
                                        c, m[0], en[0]);

        // gap clears outputs: R1
        win_valid = 1'b0;
        @(negedge clk);
        compare('0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule